// File: doc/BRIEF.md
# Decimal Character Address Decoder

This block turns a storage address written as three six-bit characters into a binary memory index. Each character holds two zone bits (B in bit 5, A in bit 4) above a four-bit numeric code (weights 8, 4, 2, 1 in bits 3 to 0). The numeric codes of the hundreds, tens and units characters form a decimal value from 000 to 999. The zone bits of the hundreds character and the units character add multiples of one and four thousand, which gives 16000 reachable locations.

The zone bits of the middle character name an index register. When one is named, the value of that register is supplied on a separate input and added to the decoded address, wrapping at the configured memory size. An invalid numeric code in any character raises a hard-halt request. A decoded address beyond the configured memory raises a range error. The decoder registers its results: they appear one clock cycle after an input strobe, together with a one-cycle valid pulse.

Top module: `adec_top`

## Requirements
- R1: Numeric code 1010 means digit 0, and codes 0001 to 1001 mean digits 1 to 9. The base address is 100×hundreds + 10×tens + units, using the characters on addrHi, addrMid and addrLo.
- R2: The zone bits of addrHi add thousands: A alone (bits[5:4]=01) adds 1000, B alone (10) adds 2000, and both (11) add 3000.
- R3: The zone bits of addrLo add 4000 for A alone (01), 8000 for B alone (10) and 12000 for both (11).
- R4: outIdxSel reports bits[5:4] of addrMid as {B,A}. The value 00 means no indexing, and only then is idxVal ignored.
- R5: A numeric code of 0000 or 1011 to 1111 in any character sets outHalt=1 and forces outIndex=0 and outRange=0.
- R6: memSizeSel selects the memory size: 0=1400, 1=2000, 2=4000, 3=8000, 4 to 7=16000. A valid address (zone increments included, before indexing) at or above that size sets outRange=1 and outIndex=0.
- R7: For a valid, in-range address with outIdxSel≠00, outIndex = (address + idxVal) mod memory size, with idxVal sampled together with the strobe.
- R8: outValid is high for exactly the cycle after each cycle in which addrValid is high. All result outputs change only after a strobe and otherwise hold their values.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Strobe: the address characters are present |
| addrHi | input | 6 | Hundreds character {B,A,8,4,2,1} |
| addrMid | input | 6 | Tens character; its zone bits select an index register |
| addrLo | input | 6 | Units character |
| memSizeSel | input | 3 | Memory size code |
| idxVal | input | 14 | Value of the selected index register |
| outValid | output | 1 | Result pulse, one cycle after the strobe |
| outIndex | output | 14 | Binary memory index |
| outIdxSel | output | 2 | Selected index register, 0 when there is none |
| outHalt | output | 1 | Hard-halt request for an invalid digit |
| outRange | output | 1 | Address exceeds the configured memory |

## Verification
The assertions assume that memSizeSel and idxVal are stable in the cycle of a strobe and that reset is held for at least one clock edge. The bound on outIndex also relies on the configured size being captured at the same edge as the address. The bench drives every input on the falling clock edge, holds addrValid for one cycle only, and returns the strobe to low before it samples. Indexed cases keep idxVal within 14 bits, including the largest value 16383, which wraps several times in the smallest memory.

// File: rtl/adec_pkg.sv
package adec_pkg;

  localparam int ADDR_W = 14;
  localparam int CHAR_W = 6;
  localparam int NUM_W  = 4;
  localparam int ZONE_W = 2;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic load;
  } adec_strobe_t;

  function automatic int sizeFromSel(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1400;
      3'd1:    return 2000;
      3'd2:    return 4000;
      3'd3:    return 8000;
      default: return 16000;
    endcase
  endfunction

endpackage

// File: rtl/adec_digit.sv
module adec_digit
  import adec_pkg::*;
(
  input  logic [NUM_W-1:0] numCode,
  output logic [NUM_W-1:0] digit,
  output logic             digitOk
);

  always_comb begin
    digit   = '0;
    digitOk = 1'b0;
    if (numCode == 4'b1010) begin
      digit   = '0;
      digitOk = 1'b1;
    end else if (numCode >= 4'd1 && numCode <= 4'd9) begin
      digit   = numCode;
      digitOk = 1'b1;
    end
  end

endmodule

// File: rtl/adec_ctrl.sv
module adec_ctrl
  import adec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrValid,
  output adec_strobe_t strb,
  output logic         outValid
);

  logic validQ;

  always_comb strb.load = addrValid;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= addrValid;
  end

  assign outValid = validQ;

  assert_valid_after_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> outValid);
  assert_no_valid_without_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !outValid);

endmodule

// File: rtl/adec_datapath.sv
module adec_datapath
  import adec_pkg::*;
#(
  parameter bit INDEX_EN = 1'b1
)(
  input  logic               clk,
  input  logic               rstN,
  input  adec_strobe_t       strb,
  input  logic [CHAR_W-1:0]  addrHi,
  input  logic [CHAR_W-1:0]  addrMid,
  input  logic [CHAR_W-1:0]  addrLo,
  input  logic [SEL_W-1:0]   memSizeSel,
  input  logic [ADDR_W-1:0]  idxVal,
  output logic [ADDR_W-1:0]  outIndex,
  output logic [ZONE_W-1:0]  outIdxSel,
  output logic               outHalt,
  output logic               outRange
);

  localparam int NCH   = 3;
  localparam int SUM_W = ADDR_W + 1;

  logic [CHAR_W-1:0] chr [NCH];
  logic [NUM_W-1:0]  dig [NCH];
  logic [NCH-1:0]    digOk;

  assign chr[0] = addrHi;
  assign chr[1] = addrMid;
  assign chr[2] = addrLo;

  for (genvar g = 0; g < NCH; g++) begin : gDig
    adec_digit u_digit (
      .numCode (chr[g][NUM_W-1:0]),
      .digit   (dig[g]),
      .digitOk (digOk[g])
    );
  end

  logic [ZONE_W-1:0] hiZone, midZone, loZone;
  assign hiZone  = addrHi[CHAR_W-1:NUM_W];
  assign midZone = addrMid[CHAR_W-1:NUM_W];
  assign loZone  = addrLo[CHAR_W-1:NUM_W];

  int                baseInt;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] sizeLim;
  logic              allOk, inRange;

  always_comb begin
    baseInt = int'(dig[0]) * 100 + int'(dig[1]) * 10 + int'(dig[2])
            + int'(hiZone) * 1000 + int'(loZone) * 4000;
    baseAddr = ADDR_W'(baseInt);
    sizeLim  = ADDR_W'(sizeFromSel(memSizeSel));
    allOk    = &digOk;
    inRange  = baseAddr < sizeLim;
  end

  logic [ADDR_W-1:0] resolved;

  if (INDEX_EN) begin : gIdx
    logic [SUM_W-1:0] sumVal, modVal;
    always_comb begin
      sumVal = {1'b0, baseAddr} + {1'b0, idxVal};
      case (memSizeSel)
        3'd0:    modVal = sumVal % SUM_W'(1400);
        3'd1:    modVal = sumVal % SUM_W'(2000);
        3'd2:    modVal = sumVal % SUM_W'(4000);
        3'd3:    modVal = sumVal % SUM_W'(8000);
        default: modVal = sumVal % SUM_W'(16000);
      endcase
      resolved = (midZone != '0) ? modVal[ADDR_W-1:0] : baseAddr;
    end
  end else begin : gNoIdx
    logic [ADDR_W-1:0] unusedIdx;
    assign unusedIdx = idxVal;
    always_comb resolved = baseAddr;
  end

  logic [ADDR_W-1:0] indexQ, sizeLimQ;
  logic [ZONE_W-1:0] idxSelQ;
  logic              haltQ, rangeQ;
  logic              loadEn;

  assign loadEn = strb.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ   <= '0;
      idxSelQ  <= '0;
      haltQ    <= 1'b0;
      rangeQ   <= 1'b0;
      sizeLimQ <= ADDR_W'(1400);
    end else if (loadEn) begin
      idxSelQ  <= midZone;
      haltQ    <= !allOk;
      rangeQ   <= allOk && !inRange;
      indexQ   <= (allOk && inRange) ? resolved : '0;
      sizeLimQ <= sizeLim;
    end
  end

  assign outIndex  = indexQ;
  assign outIdxSel = idxSelQ;
  assign outHalt   = haltQ;
  assign outRange  = rangeQ;

  assert_halt_forces_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |-> (indexQ == '0 && !rangeQ));
  assert_index_below_size_R6: assert property (@(posedge clk) disable iff (!rstN)
    indexQ < sizeLimQ);
  assert_range_forces_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    rangeQ |-> indexQ == '0);
  assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> ($stable(indexQ) && $stable(idxSelQ) && $stable(haltQ) && $stable(rangeQ)));

endmodule

// File: rtl/adec_top.sv
module adec_top
  import adec_pkg::*;
#(
  parameter bit INDEX_EN = 1'b1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  input  logic [5:0]  addrHi,
  input  logic [5:0]  addrMid,
  input  logic [5:0]  addrLo,
  input  logic [2:0]  memSizeSel,
  input  logic [13:0] idxVal,
  output logic        outValid,
  output logic [13:0] outIndex,
  output logic [1:0]  outIdxSel,
  output logic        outHalt,
  output logic        outRange
);

  adec_strobe_t strb;

  adec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrValid (addrValid),
    .strb      (strb),
    .outValid  (outValid)
  );

  adec_datapath #(.INDEX_EN(INDEX_EN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addrHi     (addrHi),
    .addrMid    (addrMid),
    .addrLo     (addrLo),
    .memSizeSel (memSizeSel),
    .idxVal     (idxVal),
    .outIndex   (outIndex),
    .outIdxSel  (outIdxSel),
    .outHalt    (outHalt),
    .outRange   (outRange)
  );

endmodule

// File: tb/adec_top_tb.sv
module adec_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [5:0]  addrHi = '0, addrMid = '0, addrLo = '0;
  logic [2:0]  memSizeSel = '0;
  logic [13:0] idxVal = '0;
  logic        outValid;
  logic [13:0] outIndex;
  logic [1:0]  outIdxSel;
  logic        outHalt, outRange;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adec_top u_dut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid),
    .addrHi(addrHi), .addrMid(addrMid), .addrLo(addrLo),
    .memSizeSel(memSizeSel), .idxVal(idxVal),
    .outValid(outValid), .outIndex(outIndex), .outIdxSel(outIdxSel),
    .outHalt(outHalt), .outRange(outRange)
  );

  function automatic logic [5:0] mk(input logic [1:0] zone, input int d);
    return {zone, (d == 0) ? 4'b1010 : 4'(d)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one strobe, sample the registered result one cycle later
  task automatic apply(input logic [5:0] h, input logic [5:0] m, input logic [5:0] l,
                       input logic [2:0] sz, input int idx);
    @(negedge clk);
    addrHi = h; addrMid = m; addrLo = l; memSizeSel = sz; idxVal = 14'(idx);
    addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic expectOk(input string req, input int idx, input int sel);
    chk(req, "valid", int'(outValid), 1);
    chk(req, "index", int'(outIndex), idx);
    chk(req, "sel",   int'(outIdxSel), sel);
    chk(req, "halt",  int'(outHalt), 0);
    chk(req, "range", int'(outRange), 0);
  endtask

  task automatic testReset();
    chk("R9", "valid", int'(outValid), 0);
    chk("R9", "index", int'(outIndex), 0);
    chk("R9", "sel",   int'(outIdxSel), 0);
    chk("R9", "halt",  int'(outHalt), 0);
    chk("R9", "range", int'(outRange), 0);
  endtask

  task automatic testDigits();
    apply(mk(0,1), mk(0,2), mk(0,3), 3'd4, 0); expectOk("R1", 123, 0);
    apply(mk(0,0), mk(0,0), mk(0,0), 3'd4, 0); expectOk("R1", 0, 0);
    apply(mk(0,9), mk(0,0), mk(0,9), 3'd4, 0); expectOk("R1", 909, 0);
  endtask

  task automatic testHighZone();
    apply(mk(2'b01,4), mk(0,5), mk(0,6), 3'd4, 0); expectOk("R2", 1456, 0);
    apply(mk(2'b10,4), mk(0,5), mk(0,6), 3'd4, 0); expectOk("R2", 2456, 0);
    apply(mk(2'b11,4), mk(0,5), mk(0,6), 3'd4, 0); expectOk("R2", 3456, 0);
  endtask

  task automatic testLowZone();
    apply(mk(0,0), mk(0,0), mk(2'b01,7), 3'd4, 0); expectOk("R3", 4007, 0);
    apply(mk(0,0), mk(0,0), mk(2'b10,7), 3'd4, 0); expectOk("R3", 8007, 0);
    apply(mk(2'b11,9), mk(0,9), mk(2'b11,9), 3'd4, 0); expectOk("R3", 15999, 0);
  endtask

  task automatic testIdxSel();
    apply(mk(0,2), mk(2'b01,1), mk(0,0), 3'd4, 0); expectOk("R4", 210, 1);
    apply(mk(0,2), mk(2'b10,1), mk(0,0), 3'd4, 0); expectOk("R4", 210, 2);
    apply(mk(0,2), mk(2'b11,1), mk(0,0), 3'd4, 0); expectOk("R4", 210, 3);
    // no selection: idxVal must be ignored
    apply(mk(0,2), mk(0,1), mk(0,0), 3'd4, 77); expectOk("R4", 210, 0);
  endtask

  task automatic testInvalid();
    apply(mk(0,1), mk(0,2), 6'b000000, 3'd4, 0);
    chk("R5", "halt blank", int'(outHalt), 1);
    chk("R5", "index blank", int'(outIndex), 0);
    chk("R5", "range blank", int'(outRange), 0);
    apply(6'b001011, mk(0,2), mk(0,3), 3'd0, 0);
    chk("R5", "halt 1011", int'(outHalt), 1);
    chk("R5", "range 1011", int'(outRange), 0);
    apply(mk(0,1), 6'b111111, mk(0,3), 3'd4, 5);
    chk("R5", "halt 1111", int'(outHalt), 1);
    chk("R5", "index 1111", int'(outIndex), 0);
  endtask

  task automatic testRange();
    apply(mk(2'b01,3), mk(0,9), mk(0,9), 3'd0, 0); expectOk("R6", 1399, 0);
    apply(mk(2'b01,4), mk(0,0), mk(0,0), 3'd0, 0);
    chk("R6", "range 1400", int'(outRange), 1);
    chk("R6", "index 1400", int'(outIndex), 0);
    chk("R6", "halt 1400", int'(outHalt), 0);
    apply(mk(2'b11,9), mk(0,9), mk(0,9), 3'd2, 0); expectOk("R6", 3999, 0);
    apply(mk(0,0), mk(0,0), mk(2'b01,0), 3'd2, 0);
    chk("R6", "range 4000", int'(outRange), 1);
    apply(mk(2'b01,9), mk(0,9), mk(0,9), 3'd1, 0); expectOk("R6", 1999, 0);
    apply(mk(2'b11,9), mk(0,9), mk(2'b01,9), 3'd3, 0); expectOk("R6", 7999, 0);
    apply(mk(0,0), mk(0,0), mk(2'b10,0), 3'd3, 0);
    chk("R6", "range 8000", int'(outRange), 1);
    apply(mk(2'b11,9), mk(0,9), mk(2'b11,9), 3'd7, 0); expectOk("R6", 15999, 0);
  endtask

  task automatic testIndexAdd();
    apply(mk(2'b11,9), mk(2'b01,9), mk(2'b11,9), 3'd4, 5); expectOk("R7", 4, 1);
    apply(mk(0,1), mk(2'b10,0), mk(0,0), 3'd0, 16383); expectOk("R7", 1083, 2);
    apply(mk(0,5), mk(2'b11,0), mk(0,0), 3'd1, 300); expectOk("R7", 800, 3);
    // out-of-range base is not rescued by indexing
    apply(mk(2'b10,0), mk(2'b01,0), mk(0,0), 3'd1, 10);
    chk("R7", "range indexed", int'(outRange), 1);
    chk("R7", "index indexed", int'(outIndex), 0);
  endtask

  task automatic testTiming();
    apply(mk(0,3), mk(0,3), mk(0,3), 3'd4, 0); expectOk("R8", 333, 0);
    // change inputs without a strobe: outputs must hold
    addrHi = mk(0,7); addrLo = 6'b000000;
    @(negedge clk);
    chk("R8", "valid drop", int'(outValid), 0);
    chk("R8", "index hold", int'(outIndex), 333);
    chk("R8", "halt hold", int'(outHalt), 0);
    @(negedge clk);
    chk("R8", "index hold2", int'(outIndex), 333);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDigits();
    testHighZone();
    testLowZone();
    testIdxSel();
    testInvalid();
    testRange();
    testIndexAdd();
    testTiming();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule